// File: doc/BRIEF.md
# Layer Priority Video Mixer

This block builds the final pixel color of a video display from several pixel sources that arrive in step with the raster. Three bitmap planes and three tilemap planes each present a color and an opacity flag for every pixel. A configuration field places any of these six sources into one of three ordered layer slots, with slot 0 in front. A sprite plane sits in front of all three slots. A text plane comes next, and then a border frame. Wherever nothing opaque lands, the result is a programmable background color. Optional per-channel gamma tables remap the result, and one register stage drives the 24-bit RGB output together with delayed sync and display-enable signals.

Color lookup from palette indices is done upstream, so every source already delivers RGB. The gamma tables are loaded through a simple write port, one channel at a time. The raster position and the active screen size come in as ports, which lets the border follow the current video mode.

Top module: `vmix_top`

## Requirements
- R1: Each slot holds a 3-bit code in `cfg_slots` (slot n at bits [3n+2:3n]). Codes 0, 1 and 2 select bitmaps 0 to 2 (`src_rgb` lanes 0 to 2). Codes 4, 5 and 6 select tilemaps 0 to 2 (lanes 3 to 5). Codes 3 and 7 select nothing, and that slot is transparent.
- R2: Slot 0 covers slot 1, and slot 1 covers slot 2. Where a selected source is not opaque, the next slot behind it shows through.
- R3: A bitmap source is drawn only when `cfg_graph_en` and `cfg_bmp_en` are both set. A tilemap source needs `cfg_graph_en` and `cfg_tile_en`. The sprite plane needs `cfg_graph_en` and `cfg_spr_en`.
- R4: An opaque sprite pixel covers every slot but lies behind the text plane and the border.
- R5: With `cfg_text_en` set, a text foreground pixel shows `txt_fg_rgb` in front of all graphics. With `cfg_overlay` clear, a text background pixel shows `txt_bg_rgb` and hides all graphics.
- R6: With `cfg_overlay` set and `cfg_ovl_idx0` clear, every text background pixel is transparent. With both set, only background index 0 is transparent and any other index shows `txt_bg_rgb`.
- R7: With `cfg_brd_en` set, a pixel shows `cfg_brd_rgb` in front of everything when either of these holds:
  - `pix_x < cfg_brd_w` or `pix_x + cfg_brd_w >= scr_w`
  - `pix_y < cfg_brd_h` or `pix_y + cfg_brd_h >= scr_h`
- R8: A pixel left transparent by every enabled plane shows `cfg_bg_rgb`.
- R9: With `cfg_gamma_en` set, each output channel is its own 256-entry table indexed by the mixed channel value. A table entry is written at a clock edge with `lut_we`, with `lut_sel` choosing the table (0 blue, 1 green, 2 red). Writes with `lut_sel` 3 change no table.
- R10: `rgb_o` shows the pixel of the inputs one clock earlier. It is all zero in any cycle that follows a cycle with `de_i` low.
- R11: `de_o`, `hs_o` and `vs_o` repeat `de_i`, `hs_i` and `vs_i` one clock later. While `cfg_sleep` is set, `hs_o` and `vs_o` are forced low.
- R12: During reset, `rgb_o`, `de_o`, `hs_o` and `vs_o` are zero.

RGB buses put red in bits [23:16], green in bits [15:8] and blue in bits [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x | input | XW | Raster column |
| pix_y | input | YW | Raster row |
| scr_w | input | XW | Active width in pixels |
| scr_h | input | YW | Active height in lines |
| de_i | input | 1 | Display enable |
| hs_i | input | 1 | Horizontal sync |
| vs_i | input | 1 | Vertical sync |
| src_rgb | input | 6*24 | Six source colors, bitmaps in lanes 0-2, tilemaps in lanes 3-5 |
| src_opq | input | 6 | Per-source opacity |
| spr_rgb | input | 24 | Sprite color |
| spr_opq | input | 1 | Sprite opacity |
| txt_fg_on | input | 1 | Text pixel is foreground |
| txt_fg_rgb | input | 24 | Text foreground color |
| txt_bg_rgb | input | 24 | Text background color |
| txt_bg_idx | input | 4 | Text background color index |
| cfg_text_en | input | 1 | Text plane enable |
| cfg_overlay | input | 1 | Text background transparency enable |
| cfg_ovl_idx0 | input | 1 | Only background index 0 transparent |
| cfg_graph_en | input | 1 | Global graphics enable |
| cfg_bmp_en | input | 1 | Bitmap enable |
| cfg_tile_en | input | 1 | Tilemap enable |
| cfg_spr_en | input | 1 | Sprite enable |
| cfg_gamma_en | input | 1 | Gamma enable |
| cfg_sleep | input | 1 | Monitor sleep, suppresses syncs |
| cfg_slots | input | 9 | Three 3-bit slot codes |
| cfg_brd_en | input | 1 | Border enable |
| cfg_brd_w | input | BW | Border width in pixels |
| cfg_brd_h | input | BW | Border height in lines |
| cfg_brd_rgb | input | 24 | Border color |
| cfg_bg_rgb | input | 24 | Background color |
| lut_we | input | 1 | Gamma table write strobe |
| lut_sel | input | 2 | Gamma table select |
| lut_addr | input | 8 | Gamma table entry |
| lut_wdata | input | 8 | Gamma table write value |
| rgb_o | output | 24 | Mixed pixel |
| de_o | output | 1 | Delayed display enable |
| hs_o | output | 1 | Delayed horizontal sync |
| vs_o | output | 1 | Delayed vertical sync |

## Verification
The bench builds the mixer with its default parameters: three slots, 8-bit channels, 12-bit raster counters and an 8-bit border size. It drives a small 64 by 48 screen through the size ports, which puts all four border edges and the exact edge-threshold columns and rows within a few directed steps. It loads three distinct gamma tables so that a swapped channel or a misplaced table write shows up in every gamma-enabled pixel.

// File: rtl/vmix_pkg.sv
package vmix_pkg;

    localparam int CH_W   = 8;
    localparam int RGB_W  = 3 * CH_W;
    localparam int CODE_W = 3;
    localparam int LUT_N  = 1 << CH_W;

    typedef struct packed {
        logic [CH_W-1:0] r;
        logic [CH_W-1:0] g;
        logic [CH_W-1:0] b;
    } rgb_t;

    typedef struct packed {
        logic opq;
        rgb_t c;
    } pix_t;

    typedef enum logic [1:0] {
        CH_BLUE  = 2'd0,
        CH_GREEN = 2'd1,
        CH_RED   = 2'd2,
        CH_NONE  = 2'd3
    } chan_e;

    typedef struct packed {
        logic              hit;
        logic              is_tile;
        logic [CODE_W-2:0] idx;
    } pick_t;

    // Top code bit selects the tilemap group; the low bits index inside it.
    function automatic pick_t decode_code(input logic [CODE_W-1:0] code,
                                          input int nb, input int nt);
        pick_t p;
        p.is_tile = code[CODE_W-1];
        p.idx     = code[CODE_W-2:0];
        p.hit     = p.is_tile ? (int'(p.idx) < nt) : (int'(p.idx) < nb);
        return p;
    endfunction

endpackage

// File: rtl/vmix_slot_sel.sv
module vmix_slot_sel
    import vmix_pkg::*;
#(
    parameter int NBMP  = 3,
    parameter int NTILE = 3
) (
    input  logic [CODE_W-1:0] code,
    input  rgb_t [NBMP-1:0]   bmp_c,
    input  logic [NBMP-1:0]   bmp_opq,
    input  rgb_t [NTILE-1:0]  tile_c,
    input  logic [NTILE-1:0]  tile_opq,
    input  logic              bmp_ok,
    input  logic              tile_ok,
    output pix_t              px
);

    pick_t pk;

    always_comb begin
        pk = decode_code(code, NBMP, NTILE);
        px = '0;
        if (pk.hit) begin
            if (pk.is_tile) begin
                if (tile_ok && tile_opq[pk.idx]) begin
                    px.opq = 1'b1;
                    px.c   = tile_c[pk.idx];
                end
            end else begin
                if (bmp_ok && bmp_opq[pk.idx]) begin
                    px.opq = 1'b1;
                    px.c   = bmp_c[pk.idx];
                end
            end
        end
    end

endmodule

// File: rtl/vmix_border.sv
module vmix_border #(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int BW = 8
) (
    input  logic [XW-1:0] pix_x,
    input  logic [YW-1:0] pix_y,
    input  logic [XW-1:0] scr_w,
    input  logic [YW-1:0] scr_h,
    input  logic [BW-1:0] brd_w,
    input  logic [BW-1:0] brd_h,
    output logic          hit
);

    localparam int XS = ((XW > BW) ? XW : BW) + 1;
    localparam int YS = ((YW > BW) ? YW : BW) + 1;

    logic [XS-1:0] x_far;
    logic [YS-1:0] y_far;
    logic          near_l, near_r, near_t, near_b;

    always_comb begin
        x_far  = XS'(pix_x) + XS'(brd_w);
        y_far  = YS'(pix_y) + YS'(brd_h);
        near_l = XS'(pix_x) < XS'(brd_w);
        near_r = x_far >= XS'(scr_w);
        near_t = YS'(pix_y) < YS'(brd_h);
        near_b = y_far >= YS'(scr_h);
        hit    = near_l | near_r | near_t | near_b;
    end

endmodule

// File: rtl/vmix_compose.sv
module vmix_compose
    import vmix_pkg::*;
#(
    parameter int NSLOT = 3,
    parameter int IDXW  = 4
) (
    input  logic             brd_hit,
    input  rgb_t             brd_c,
    input  rgb_t             bg_c,
    input  logic             text_en,
    input  logic             overlay,
    input  logic             ovl_idx0,
    input  logic             fg_on,
    input  logic [IDXW-1:0]  bg_idx,
    input  rgb_t             fg_c,
    input  rgb_t             tbg_c,
    input  pix_t             spr,
    input  pix_t [NSLOT-1:0] slots,
    output rgb_t             mix
);

    logic tbg_solid;

    always_comb begin
        tbg_solid = text_en & (~overlay | (ovl_idx0 & (bg_idx != '0)));
        // Paint from back to front; each later hit covers the earlier one.
        mix = bg_c;
        for (int s = NSLOT - 1; s >= 0; s--) begin
            if (slots[s].opq) mix = slots[s].c;
        end
        if (spr.opq)          mix = spr.c;
        if (tbg_solid)        mix = tbg_c;
        if (text_en && fg_on) mix = fg_c;
        if (brd_hit)          mix = brd_c;
    end

endmodule

// File: rtl/vmix_gamma.sv
module vmix_gamma
    import vmix_pkg::*;
(
    input  logic            clk,
    input  logic            en,
    input  logic            we,
    input  chan_e           sel,
    input  logic [CH_W-1:0] addr,
    input  logic [CH_W-1:0] wdata,
    input  rgb_t            din,
    output rgb_t            dout
);

    logic [CH_W-1:0] ch_in  [3];
    logic [CH_W-1:0] ch_out [3];

    assign ch_in[0] = din.b;
    assign ch_in[1] = din.g;
    assign ch_in[2] = din.r;

    for (genvar ch = 0; ch < 3; ch++) begin : g_tab
        logic [CH_W-1:0] tab [LUT_N];

        always_ff @(posedge clk) begin
            if (we && (sel == chan_e'(ch))) tab[addr] <= wdata;
        end

        assign ch_out[ch] = tab[ch_in[ch]];
    end

    always_comb begin
        if (en) begin
            dout.b = ch_out[0];
            dout.g = ch_out[1];
            dout.r = ch_out[2];
        end else begin
            dout = din;
        end
    end

endmodule

// File: rtl/vmix_top.sv
module vmix_top
    import vmix_pkg::*;
#(
    parameter int XW    = 12,
    parameter int YW    = 12,
    parameter int BW    = 8,
    parameter int IDXW  = 4,
    parameter int NBMP  = 3,
    parameter int NTILE = 3,
    parameter int NSLOT = 3
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [XW-1:0]                 pix_x,
    input  logic [YW-1:0]                 pix_y,
    input  logic [XW-1:0]                 scr_w,
    input  logic [YW-1:0]                 scr_h,
    input  logic                          de_i,
    input  logic                          hs_i,
    input  logic                          vs_i,
    input  logic [(NBMP+NTILE)*RGB_W-1:0] src_rgb,
    input  logic [NBMP+NTILE-1:0]         src_opq,
    input  logic [RGB_W-1:0]              spr_rgb,
    input  logic                          spr_opq,
    input  logic                          txt_fg_on,
    input  logic [RGB_W-1:0]              txt_fg_rgb,
    input  logic [RGB_W-1:0]              txt_bg_rgb,
    input  logic [IDXW-1:0]               txt_bg_idx,
    input  logic                          cfg_text_en,
    input  logic                          cfg_overlay,
    input  logic                          cfg_ovl_idx0,
    input  logic                          cfg_graph_en,
    input  logic                          cfg_bmp_en,
    input  logic                          cfg_tile_en,
    input  logic                          cfg_spr_en,
    input  logic                          cfg_gamma_en,
    input  logic                          cfg_sleep,
    input  logic [NSLOT*CODE_W-1:0]       cfg_slots,
    input  logic                          cfg_brd_en,
    input  logic [BW-1:0]                 cfg_brd_w,
    input  logic [BW-1:0]                 cfg_brd_h,
    input  logic [RGB_W-1:0]              cfg_brd_rgb,
    input  logic [RGB_W-1:0]              cfg_bg_rgb,
    input  logic                          lut_we,
    input  logic [1:0]                    lut_sel,
    input  logic [CH_W-1:0]               lut_addr,
    input  logic [CH_W-1:0]               lut_wdata,
    output logic [RGB_W-1:0]              rgb_o,
    output logic                          de_o,
    output logic                          hs_o,
    output logic                          vs_o
);

    rgb_t [NBMP-1:0]  bmp_c;
    rgb_t [NTILE-1:0] tile_c;
    pix_t [NSLOT-1:0] slot_px;
    pix_t             spr_px;
    logic             bmp_ok, tile_ok;
    logic             brd_hit_raw;
    rgb_t             mixed, graded;

    assign bmp_ok  = cfg_graph_en & cfg_bmp_en;
    assign tile_ok = cfg_graph_en & cfg_tile_en;

    for (genvar i = 0; i < NBMP; i++) begin : g_bmp
        assign bmp_c[i] = rgb_t'(src_rgb[i*RGB_W +: RGB_W]);
    end

    for (genvar i = 0; i < NTILE; i++) begin : g_tile
        assign tile_c[i] = rgb_t'(src_rgb[(NBMP+i)*RGB_W +: RGB_W]);
    end

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        vmix_slot_sel #(
            .NBMP (NBMP),
            .NTILE(NTILE)
        ) u_sel (
            .code    (cfg_slots[s*CODE_W +: CODE_W]),
            .bmp_c   (bmp_c),
            .bmp_opq (src_opq[NBMP-1:0]),
            .tile_c  (tile_c),
            .tile_opq(src_opq[NBMP+NTILE-1:NBMP]),
            .bmp_ok  (bmp_ok),
            .tile_ok (tile_ok),
            .px      (slot_px[s])
        );
    end

    assign spr_px.opq = spr_opq & cfg_graph_en & cfg_spr_en;
    assign spr_px.c   = rgb_t'(spr_rgb);

    vmix_border #(
        .XW(XW),
        .YW(YW),
        .BW(BW)
    ) u_border (
        .pix_x(pix_x),
        .pix_y(pix_y),
        .scr_w(scr_w),
        .scr_h(scr_h),
        .brd_w(cfg_brd_w),
        .brd_h(cfg_brd_h),
        .hit  (brd_hit_raw)
    );

    vmix_compose #(
        .NSLOT(NSLOT),
        .IDXW (IDXW)
    ) u_compose (
        .brd_hit (brd_hit_raw & cfg_brd_en),
        .brd_c   (rgb_t'(cfg_brd_rgb)),
        .bg_c    (rgb_t'(cfg_bg_rgb)),
        .text_en (cfg_text_en),
        .overlay (cfg_overlay),
        .ovl_idx0(cfg_ovl_idx0),
        .fg_on   (txt_fg_on),
        .bg_idx  (txt_bg_idx),
        .fg_c    (rgb_t'(txt_fg_rgb)),
        .tbg_c   (rgb_t'(txt_bg_rgb)),
        .spr     (spr_px),
        .slots   (slot_px),
        .mix     (mixed)
    );

    vmix_gamma u_gamma (
        .clk  (clk),
        .en   (cfg_gamma_en),
        .we   (lut_we),
        .sel  (chan_e'(lut_sel)),
        .addr (lut_addr),
        .wdata(lut_wdata),
        .din  (mixed),
        .dout (graded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb_o <= '0;
            de_o  <= 1'b0;
            hs_o  <= 1'b0;
            vs_o  <= 1'b0;
        end else begin
            rgb_o <= de_i ? RGB_W'(graded) : '0;
            de_o  <= de_i;
            hs_o  <= hs_i & ~cfg_sleep;
            vs_o  <= vs_i & ~cfg_sleep;
        end
    end

endmodule

// File: rtl/vmix_chk.sv
module vmix_chk
    import vmix_pkg::*;
#(
    parameter int XW = 12,
    parameter int YW = 12,
    parameter int BW = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [XW-1:0]    pix_x,
    input logic [YW-1:0]    pix_y,
    input logic [XW-1:0]    scr_w,
    input logic [YW-1:0]    scr_h,
    input logic             de_i,
    input logic             hs_i,
    input logic             vs_i,
    input logic             cfg_text_en,
    input logic             cfg_graph_en,
    input logic             cfg_gamma_en,
    input logic             cfg_sleep,
    input logic             cfg_brd_en,
    input logic [BW-1:0]    cfg_brd_w,
    input logic [BW-1:0]    cfg_brd_h,
    input logic [RGB_W-1:0] cfg_brd_rgb,
    input logic [RGB_W-1:0] cfg_bg_rgb,
    input logic [RGB_W-1:0] rgb_o,
    input logic             de_o,
    input logic             hs_o,
    input logic             vs_o
);

    localparam int SW = ((XW > YW) ? XW : YW) + BW + 1;

    logic on_edge;
    assign on_edge = (SW'(pix_x) < SW'(cfg_brd_w))
                   || (SW'(pix_x) + SW'(cfg_brd_w) >= SW'(scr_w))
                   || (SW'(pix_y) < SW'(cfg_brd_h))
                   || (SW'(pix_y) + SW'(cfg_brd_h) >= SW'(scr_h));

    // R10: blanked input gives a black output pixel
    a_r10_blank: assert property (@(posedge clk) disable iff (rst)
        !de_i |=> (rgb_o == '0));

    // R11: sleep forces both syncs low
    a_r11_sleep: assert property (@(posedge clk) disable iff (rst)
        cfg_sleep |=> (!hs_o && !vs_o));

    // R11: awake syncs and enable follow one cycle later
    a_r11_follow: assert property (@(posedge clk) disable iff (rst)
        !cfg_sleep |=> (hs_o == $past(hs_i)) && (vs_o == $past(vs_i))
                       && (de_o == $past(de_i)));

    // R7: border frame wins over every plane
    a_r7_border: assert property (@(posedge clk) disable iff (rst)
        (de_i && cfg_brd_en && !cfg_gamma_en && on_edge)
            |=> (rgb_o == $past(cfg_brd_rgb)));

    // R8 and R3: with text and graphics off only the background remains
    a_r8_background: assert property (@(posedge clk) disable iff (rst)
        (de_i && !cfg_brd_en && !cfg_text_en && !cfg_graph_en && !cfg_gamma_en)
            |=> (rgb_o == $past(cfg_bg_rgb)));

endmodule

bind vmix_top vmix_chk #(.XW(XW), .YW(YW), .BW(BW)) u_chk (.*);

// File: tb/vmix_top_tb_top.sv
module vmix_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic [11:0]  pix_x, pix_y, scr_w, scr_h;
    logic         de_i, hs_i, vs_i;
    logic [143:0] src_rgb;
    logic [5:0]   src_opq;
    logic [23:0]  spr_rgb;
    logic         spr_opq;
    logic         txt_fg_on;
    logic [23:0]  txt_fg_rgb, txt_bg_rgb;
    logic [3:0]   txt_bg_idx;
    logic         cfg_text_en, cfg_overlay, cfg_ovl_idx0, cfg_graph_en;
    logic         cfg_bmp_en, cfg_tile_en, cfg_spr_en, cfg_gamma_en, cfg_sleep;
    logic [8:0]   cfg_slots;
    logic         cfg_brd_en;
    logic [7:0]   cfg_brd_w, cfg_brd_h;
    logic [23:0]  cfg_brd_rgb, cfg_bg_rgb;
    logic         lut_we;
    logic [1:0]   lut_sel;
    logic [7:0]   lut_addr, lut_wdata;
    logic [23:0]  rgb_o;
    logic         de_o, hs_o, vs_o;

    int n_checks = 0;
    int n_errors = 0;
    logic [7:0] m_lut [3][256];

    always #(CLK_PERIOD/2) clk = ~clk;

    vmix_top dut_i (.*);

    function automatic logic [7:0] lut_fn(input int sel, input int a);
        case (sel)
            0:       return 8'(255 - a);
            1:       return 8'(a ^ 8'h5A);
            default: return 8'(a * 3 + 7);
        endcase
    endfunction

    function automatic logic [23:0] model_rgb();
        logic [23:0] c;
        logic        edge_hit, tbg;
        int          code;
        if (!de_i) return 24'h0;
        edge_hit = (int'(pix_x) < int'(cfg_brd_w)) ||
                   (int'(pix_x) + int'(cfg_brd_w) >= int'(scr_w)) ||
                   (int'(pix_y) < int'(cfg_brd_h)) ||
                   (int'(pix_y) + int'(cfg_brd_h) >= int'(scr_h));
        c = cfg_bg_rgb;
        for (int s = 2; s >= 0; s--) begin
            code = int'(cfg_slots[s*3 +: 3]);
            if (code <= 2 && cfg_graph_en && cfg_bmp_en && src_opq[code])
                c = src_rgb[code*24 +: 24];
            if (code >= 4 && code <= 6 && cfg_graph_en && cfg_tile_en && src_opq[code-1])
                c = src_rgb[(code-1)*24 +: 24];
        end
        if (cfg_graph_en && cfg_spr_en && spr_opq) c = spr_rgb;
        tbg = cfg_text_en && (!cfg_overlay || (cfg_ovl_idx0 && txt_bg_idx != 4'd0));
        if (tbg) c = txt_bg_rgb;
        if (cfg_text_en && txt_fg_on) c = txt_fg_rgb;
        if (cfg_brd_en && edge_hit) c = cfg_brd_rgb;
        if (cfg_gamma_en)
            c = {m_lut[2][c[23:16]], m_lut[1][c[15:8]], m_lut[0][c[7:0]]};
        return c;
    endfunction

    task automatic chk(input string req);
        logic [23:0] e_rgb;
        logic        e_hs, e_vs, e_de;
        e_rgb = model_rgb();
        e_hs  = hs_i & ~cfg_sleep;
        e_vs  = vs_i & ~cfg_sleep;
        e_de  = de_i;
        @(posedge clk);
        #1;
        n_checks++;
        if (rgb_o !== e_rgb || hs_o !== e_hs || vs_o !== e_vs || de_o !== e_de) begin
            n_errors++;
            $display("FAIL %s: rgb=%06h hs=%b vs=%b de=%b expected rgb=%06h hs=%b vs=%b de=%b",
                     req, rgb_o, hs_o, vs_o, de_o, e_rgb, e_hs, e_vs, e_de);
        end
    endtask

    task automatic clear_all();
        pix_x = 12'd30; pix_y = 12'd20; scr_w = 12'd64; scr_h = 12'd48;
        de_i = 1'b1; hs_i = 1'b0; vs_i = 1'b0;
        for (int k = 0; k < 6; k++) src_rgb[k*24 +: 24] = 24'h111111 * (k + 1);
        src_opq = 6'h3F;
        spr_rgb = 24'hABCDEF; spr_opq = 1'b0;
        txt_fg_on = 1'b0; txt_fg_rgb = 24'hF0F0F0; txt_bg_rgb = 24'h0A0B0C; txt_bg_idx = 4'd0;
        cfg_text_en = 1'b0; cfg_overlay = 1'b0; cfg_ovl_idx0 = 1'b0; cfg_graph_en = 1'b0;
        cfg_bmp_en = 1'b0; cfg_tile_en = 1'b0; cfg_spr_en = 1'b0; cfg_gamma_en = 1'b0;
        cfg_sleep = 1'b0; cfg_slots = 9'o333;
        cfg_brd_en = 1'b0; cfg_brd_w = 8'd4; cfg_brd_h = 8'd3;
        cfg_brd_rgb = 24'hC0FFEE; cfg_bg_rgb = 24'h102030;
        lut_we = 1'b0; lut_sel = 2'd0; lut_addr = 8'd0; lut_wdata = 8'd0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_errors++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_all();
        rst = 1'b1;
        hs_i = 1'b1; vs_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R12: outputs held at zero during reset
        n_checks++;
        if (rgb_o !== 24'h0 || de_o !== 1'b0 || hs_o !== 1'b0 || vs_o !== 1'b0) begin
            n_errors++;
            $display("FAIL R12: rgb=%06h de=%b hs=%b vs=%b expected all zero", rgb_o, de_o, hs_o, vs_o);
        end
        rst = 1'b0;
        clear_all();

        // Load the three gamma tables, each distinct
        for (int s = 0; s < 3; s++) begin
            for (int a = 0; a < 256; a++) begin
                lut_we = 1'b1; lut_sel = 2'(s); lut_addr = 8'(a); lut_wdata = lut_fn(s, a);
                @(posedge clk); #1;
                m_lut[s][a] = lut_fn(s, a);
            end
        end
        lut_we = 1'b0;

        // R8: nothing enabled shows background
        chk("R8");

        // R1: every code in slot 0
        cfg_graph_en = 1'b1; cfg_bmp_en = 1'b1; cfg_tile_en = 1'b1;
        for (int code = 0; code < 8; code++) begin
            cfg_slots = {3'd3, 3'd3, 3'(code)};
            chk("R1");
        end

        // R2: slot ordering and see-through
        cfg_slots = {3'd2, 3'd4, 3'd1};
        chk("R2");
        src_opq = 6'b111101;
        chk("R2");
        src_opq = 6'b110101;
        chk("R2");
        src_opq = 6'b110001;
        chk("R2");
        src_opq = 6'h3F;

        // R3: per-type and global gating
        cfg_bmp_en = 1'b0;
        chk("R3");
        cfg_bmp_en = 1'b1; cfg_tile_en = 1'b0; cfg_slots = {3'd3, 3'd3, 3'd5};
        chk("R3");
        cfg_tile_en = 1'b1; cfg_graph_en = 1'b0; cfg_bmp_en = 1'b1; cfg_spr_en = 1'b1; spr_opq = 1'b1;
        chk("R3");
        cfg_graph_en = 1'b1; cfg_spr_en = 1'b0;
        chk("R3");

        // R4: sprite over slots, under text
        cfg_spr_en = 1'b1;
        chk("R4");
        cfg_text_en = 1'b1; txt_fg_on = 1'b1;
        chk("R4");

        // R5: text foreground and opaque background
        txt_fg_on = 1'b0;
        chk("R5");
        txt_fg_on = 1'b1; cfg_overlay = 1'b1;
        chk("R5");

        // R6: overlay transparency rules
        txt_fg_on = 1'b0; txt_bg_idx = 4'd6;
        chk("R6");
        cfg_ovl_idx0 = 1'b1;
        chk("R6");
        txt_bg_idx = 4'd0;
        chk("R6");
        cfg_text_en = 1'b0;

        // R7: border edges and thresholds
        cfg_brd_en = 1'b1;
        chk("R7");
        pix_x = 12'd3;  chk("R7");
        pix_x = 12'd4;  chk("R7");
        pix_x = 12'd59; chk("R7");
        pix_x = 12'd60; chk("R7");
        pix_x = 12'd30; pix_y = 12'd2;  chk("R7");
        pix_y = 12'd3;  chk("R7");
        pix_y = 12'd44; chk("R7");
        pix_y = 12'd45; chk("R7");
        pix_y = 12'd20;

        // R9: gamma on several pixel kinds, then an ignored write
        cfg_gamma_en = 1'b1;
        chk("R9");
        pix_x = 12'd0; chk("R9");
        pix_x = 12'd30; cfg_brd_en = 1'b0; spr_opq = 1'b0;
        chk("R9");
        lut_we = 1'b1; lut_sel = 2'd3; lut_addr = 8'h44; lut_wdata = 8'h00;
        @(posedge clk); #1;
        lut_we = 1'b0;
        src_rgb[0 +: 24] = 24'h444444; cfg_slots = 9'o330;
        chk("R9");
        cfg_gamma_en = 1'b0;

        // R10: blanking
        de_i = 1'b0;
        chk("R10");
        de_i = 1'b1;
        chk("R10");

        // R11: sync pass-through and sleep
        hs_i = 1'b1; vs_i = 1'b0;
        chk("R11");
        hs_i = 1'b0; vs_i = 1'b1;
        chk("R11");
        cfg_sleep = 1'b1; hs_i = 1'b1;
        chk("R11");
        cfg_sleep = 1'b0;

        // Random mix covering R1 to R11
        for (int it = 0; it < 400; it++) begin
            for (int k = 0; k < 6; k++) src_rgb[k*24 +: 24] = 24'($urandom);
            src_opq      = 6'($urandom);
            spr_rgb      = 24'($urandom); spr_opq = 1'($urandom);
            txt_fg_on    = 1'($urandom);
            txt_fg_rgb   = 24'($urandom); txt_bg_rgb = 24'($urandom);
            txt_bg_idx   = 4'($urandom_range(0, 3));
            cfg_text_en  = ($urandom_range(0, 3) == 0);
            cfg_overlay  = 1'($urandom); cfg_ovl_idx0 = 1'($urandom);
            cfg_graph_en = ($urandom_range(0, 4) != 0);
            cfg_bmp_en   = 1'($urandom); cfg_tile_en = 1'($urandom); cfg_spr_en = 1'($urandom);
            cfg_gamma_en = 1'($urandom); cfg_sleep = ($urandom_range(0, 7) == 0);
            cfg_slots    = 9'($urandom);
            cfg_brd_en   = 1'($urandom);
            cfg_brd_w    = 8'($urandom_range(0, 8)); cfg_brd_h = 8'($urandom_range(0, 8));
            cfg_brd_rgb  = 24'($urandom); cfg_bg_rgb = 24'($urandom);
            pix_x        = 12'($urandom_range(0, 63)); pix_y = 12'($urandom_range(0, 47));
            de_i         = ($urandom_range(0, 7) != 0);
            hs_i         = 1'($urandom); vs_i = 1'($urandom);
            chk("R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 random");
        end

        finish_run();
    end

endmodule